// File: doc/BRIEF.md
# Serial Port Bit Clock Selector

This block produces the transmit and receive bit clocks of a synchronous serial port. Each direction builds an internal clock from one of three sources: a shared programmable divider, the clock of the opposite direction, or an external clock that arrives on that direction's own clock pad. Each direction can invert its internal clock, and each drives its clock pad through an output enable. The pad can be driven at all times, only while a transfer is active, or not at all.

All clocks are modelled on a single system clock. A clock is a registered level, and a one-cycle enable pulse marks each rising edge of the internal clock. The data-shifting logic downstream uses these pulses. The pad inputs are asynchronous, so they pass through a two-flop synchronizer before use.

The block carries no data stream, so it has no valid/ready handshake and no back-pressure. Every control and status pin is a plain level, sampled or produced on the system clock.

Top module: `sck_clk_select`

## Requirements
- R1: The transmit source select `tx_sel_i` uses this encoding: 0 picks the divider clock, 1 picks the receive-side base clock, 2 picks the synchronized transmit pad input, and the reserved value 3 behaves as 0.
- R2: The receive source select `rx_sel_i` uses the same encoding, with 1 picking the transmit-side base clock and 2 picking the synchronized receive pad input.
- R3: With `div_i` = N, where N is from 1 to 4095, the divider clock toggles every N system cycles, which gives a period of 2N cycles. With `div_i` = 0 the divider clock stays low.
- R4: Setting a direction's inversion bit inverts its internal clock (`*_clk_o`). The pad output (`*_pad_o`) always carries the uninverted selected source.
- R5: The output mode `*_mode_i` sets the pad enable one cycle later: 0 gives enable low, 1 gives enable high, 2 makes the enable follow that direction's transfer flag `*_xfer_i`, and the reserved value 3 gives enable low.
- R6: Selecting the pad as source (select = 2) together with continuous output (mode = 1) raises that direction's `*_cfg_err_o`. While it is raised, the pad enable is held low.
- R7: When both directions select each other (both selects = 1), `loop_err_o` is raised, both internal clocks are held low, and no enable pulses are issued.
- R8: The internal clock follows an external pad clock with the same period. Each enable pulse lasts exactly one cycle and coincides with the first high cycle of the internal clock.
- R9: After reset, all clocks, pulses, pad outputs, pad enables and error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | 12 | Divider half-period in system cycles; 0 stops the divider clock |
| tx_sel_i | input | 2 | Transmit clock source select |
| tx_inv_i | input | 1 | Transmit internal clock inversion |
| tx_mode_i | input | 2 | Transmit pad output mode |
| tx_xfer_i | input | 1 | Transmit transfer active |
| tx_pad_i | input | 1 | Transmit clock pad input |
| tx_pad_o | output | 1 | Transmit clock pad output value |
| tx_pad_oe | output | 1 | Transmit clock pad output enable |
| tx_clk_o | output | 1 | Transmit internal clock level |
| tx_clk_en_o | output | 1 | Transmit internal clock rising-edge pulse |
| tx_cfg_err_o | output | 1 | Transmit illegal pad-source plus continuous-output combination |
| rx_sel_i | input | 2 | Receive clock source select |
| rx_inv_i | input | 1 | Receive internal clock inversion |
| rx_mode_i | input | 2 | Receive pad output mode |
| rx_xfer_i | input | 1 | Receive transfer active |
| rx_pad_i | input | 1 | Receive clock pad input |
| rx_pad_o | output | 1 | Receive clock pad output value |
| rx_pad_oe | output | 1 | Receive clock pad output enable |
| rx_clk_o | output | 1 | Receive internal clock level |
| rx_clk_en_o | output | 1 | Receive internal clock rising-edge pulse |
| rx_cfg_err_o | output | 1 | Receive illegal pad-source plus continuous-output combination |
| loop_err_o | output | 1 | Both directions select each other |

## Verification
The bench targets the following corner cases:

- **Mutual selection loop.** A design that lets it through would oscillate or latch whatever level it held, so the bench watches for pulses while both selects are 1.
- **Inversion reaching the pad.** A design that applies the inversion bit to the pad output would make the pad equal to the inverted internal clock.
- **Reserved encodings.** Select 3 must behave as the divider. Mode 3 must keep the pad undriven.
- **Illegal pad-plus-continuous combination.** Here the pad enable must stay low, not drive a pad that is also the source.
- **Divider edges.** The bench checks a divider value of zero, which must stop the clock rather than free-run. It also checks random divider values, where an off-by-one in the counter reload would show up as a period of 2N±2.

// File: rtl/sck_pkg.sv
package sck_pkg;
  typedef enum logic [1:0] {
    SRC_DIV   = 2'd0,
    SRC_OTHER = 2'd1,
    SRC_PAD   = 2'd2,
    SRC_RSVD  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    OM_OFF  = 2'd0,
    OM_CONT = 2'd1,
    OM_XFER = 2'd2,
    OM_RSVD = 2'd3
  } omode_e;
endpackage

// File: rtl/sck_div.sv
module sck_div #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             lvl_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_o <= 1'b0;
    end else if (div_i == '0) begin
      cnt_q <= '0;
      lvl_o <= 1'b0;
    end else if (cnt_q >= div_i - 1'b1) begin
      cnt_q <= '0;
      lvl_o <= ~lvl_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_div_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i == '0) |=> !lvl_o);
endmodule

// File: rtl/sck_pad_sync.sv
module sck_pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_i,
  output logic lvl_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], pad_i};
  end

  assign lvl_o = sync_q[STAGES-1];
endmodule

// File: rtl/sck_dir.sv
module sck_dir
  import sck_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       inv_i,
  input  logic [1:0] mode_i,
  input  logic       xfer_i,
  input  logic       pad_lvl_i,
  input  logic       div_lvl_i,
  input  logic       other_base_i,
  input  logic       loop_i,
  output logic       base_o,
  output logic       clk_o,
  output logic       clk_en_o,
  output logic       pad_o,
  output logic       oe_o,
  output logic       cfg_err_o
);
  src_e   sel;
  omode_e mode;
  logic   src, clk_d, illegal, oe_d;

  assign sel  = src_e'(sel_i);
  assign mode = omode_e'(mode_i);

  // Base clock: the source without the cross term, offered to the other side.
  assign base_o = (sel == SRC_PAD) ? pad_lvl_i : div_lvl_i;

  always_comb begin
    if (loop_i)                src = 1'b0;
    else if (sel == SRC_OTHER) src = other_base_i;
    else                       src = base_o;
  end

  assign clk_d   = loop_i ? 1'b0 : (src ^ inv_i);
  assign illegal = (sel == SRC_PAD) && (mode == OM_CONT);

  always_comb begin
    unique case (mode)
      OM_CONT: oe_d = 1'b1;
      OM_XFER: oe_d = xfer_i;
      default: oe_d = 1'b0;
    endcase
    if (illegal) oe_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_o     <= 1'b0;
      clk_en_o  <= 1'b0;
      pad_o     <= 1'b0;
      oe_o      <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      clk_o     <= clk_d;
      clk_en_o  <= clk_d & ~clk_o;
      pad_o     <= src;
      oe_o      <= oe_d;
      cfg_err_o <= illegal;
    end
  end

  p_pulse_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |-> clk_o);
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |=> !clk_en_o);
  p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !oe_o);
endmodule

// File: rtl/sck_clk_select.sv
module sck_clk_select
  import sck_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       tx_sel_i,
  input  logic             tx_inv_i,
  input  logic [1:0]       tx_mode_i,
  input  logic             tx_xfer_i,
  input  logic             tx_pad_i,
  output logic             tx_pad_o,
  output logic             tx_pad_oe,
  output logic             tx_clk_o,
  output logic             tx_clk_en_o,
  output logic             tx_cfg_err_o,
  input  logic [1:0]       rx_sel_i,
  input  logic             rx_inv_i,
  input  logic [1:0]       rx_mode_i,
  input  logic             rx_xfer_i,
  input  logic             rx_pad_i,
  output logic             rx_pad_o,
  output logic             rx_pad_oe,
  output logic             rx_clk_o,
  output logic             rx_clk_en_o,
  output logic             rx_cfg_err_o,
  output logic             loop_err_o
);
  localparam int NDIR = 2;

  logic            div_lvl, loop;
  logic [1:0]      sel  [NDIR];
  logic [1:0]      mode [NDIR];
  logic [NDIR-1:0] inv, xfer, pad_in, pad_lvl, base;
  logic [NDIR-1:0] clk_lvl, clk_en, pad_out, oe, cfg_err;

  assign sel[0]  = tx_sel_i;   assign sel[1]  = rx_sel_i;
  assign mode[0] = tx_mode_i;  assign mode[1] = rx_mode_i;
  assign inv     = {rx_inv_i,  tx_inv_i};
  assign xfer    = {rx_xfer_i, tx_xfer_i};
  assign pad_in  = {rx_pad_i,  tx_pad_i};

  assign loop = (src_e'(tx_sel_i) == SRC_OTHER) && (src_e'(rx_sel_i) == SRC_OTHER);

  sck_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .lvl_o(div_lvl)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    sck_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pad_i(pad_in[d]), .lvl_o(pad_lvl[d])
    );
    sck_dir u_dir (
      .clk(clk), .rst_n(rst_n),
      .sel_i(sel[d]), .inv_i(inv[d]), .mode_i(mode[d]), .xfer_i(xfer[d]),
      .pad_lvl_i(pad_lvl[d]), .div_lvl_i(div_lvl),
      .other_base_i(base[NDIR-1-d]), .loop_i(loop),
      .base_o(base[d]), .clk_o(clk_lvl[d]), .clk_en_o(clk_en[d]),
      .pad_o(pad_out[d]), .oe_o(oe[d]), .cfg_err_o(cfg_err[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loop_err_o <= 1'b0;
    else        loop_err_o <= loop;
  end

  assign tx_pad_o = pad_out[0];  assign rx_pad_o = pad_out[1];
  assign tx_pad_oe = oe[0];      assign rx_pad_oe = oe[1];
  assign tx_clk_o = clk_lvl[0];  assign rx_clk_o = clk_lvl[1];
  assign tx_clk_en_o = clk_en[0]; assign rx_clk_en_o = clk_en[1];
  assign tx_cfg_err_o = cfg_err[0]; assign rx_cfg_err_o = cfg_err[1];

  p_loop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_err_o |-> (!tx_clk_o && !rx_clk_o && !tx_clk_en_o && !rx_clk_en_o));
endmodule

// File: tb/test_sck_clk_select.sv
module test_sck_clk_select;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] div_i = '0;
  logic [1:0]  tx_sel_i = '0, tx_mode_i = '0, rx_sel_i = '0, rx_mode_i = '0;
  logic        tx_inv_i = 0, tx_xfer_i = 0, tx_pad_i = 0;
  logic        rx_inv_i = 0, rx_xfer_i = 0, rx_pad_i = 0;
  logic        tx_pad_o, tx_pad_oe, tx_clk_o, tx_clk_en_o, tx_cfg_err_o;
  logic        rx_pad_o, rx_pad_oe, rx_clk_o, rx_clk_en_o, rx_cfg_err_o, loop_err_o;
  int          n_chk = 0, n_bad = 0, pad_half = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  sck_clk_select i_sck_clk_select (.*);

  // External pad clocks, driven away from the active edge.
  always begin
    @(negedge clk);
    if (pad_half > 0) begin
      repeat (pad_half - 1) @(negedge clk);
      tx_pad_i = ~tx_pad_i;
      rx_pad_i = ~rx_pad_i;
    end
  end

  function automatic int exp_period(int d);
    return 2 * d;
  endfunction

  function automatic logic exp_oe(logic [1:0] sel, logic [1:0] mode, logic xfer);
    if (sel == 2'd2 && mode == 2'd1) return 1'b0;
    case (mode)
      2'd1: return 1'b1;
      2'd2: return xfer;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period(bit rx, output int p);
    int c = 0;
    while (!(rx ? rx_clk_en_o : tx_clk_en_o) && c < 400) begin @(negedge clk); c++; end
    @(negedge clk);
    p = 1;
    while (!(rx ? rx_clk_en_o : tx_clk_en_o) && p < 400) begin @(negedge clk); p++; end
  endtask

  task automatic count_pulses(int n, output int tx_n, output int rx_n, output int hi);
    tx_n = 0; rx_n = 0; hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_n += int'(tx_clk_en_o);
      rx_n += int'(rx_clk_en_o);
      hi   += int'(tx_clk_o) + int'(rx_clk_o);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int p, a, b, h, mis;
    void'($urandom(32'd7781));
    settle(3);
    rst_n = 1'b1;
    settle(3);
    // R9 reset state
    chk("R9 idle", {tx_clk_o, rx_clk_o, tx_clk_en_o, rx_clk_en_o, tx_pad_o, rx_pad_o,
                    tx_pad_oe, rx_pad_oe, tx_cfg_err_o, rx_cfg_err_o, loop_err_o}, 0);

    // R3 divider period; R2 reserved select behaves as divider
    div_i = 12'd3; tx_sel_i = 2'd0; rx_sel_i = 2'd3;
    settle(20);
    period(0, p); period(0, p);
    chk("R3 period div=3", p, exp_period(3));
    mis = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); mis += int'(rx_clk_o != tx_clk_o); end
    chk("R2 reserved select follows divider", mis, 0);

    // R1 transmit from receive side; R2 receive from divider
    tx_sel_i = 2'd1; rx_sel_i = 2'd0;
    settle(4); mis = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); mis += int'(rx_clk_o != tx_clk_o); end
    chk("R1 tx follows rx base", mis, 0);

    // R4 inversion only on internal clock
    tx_sel_i = 2'd0; tx_inv_i = 1'b1; tx_mode_i = 2'd1;
    settle(4); mis = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      mis += int'(tx_clk_o == tx_pad_o) + int'(tx_pad_o != rx_clk_o);
    end
    chk("R4 pad uninverted, internal inverted", mis, 0);
    tx_inv_i = 1'b0;

    // R5 output modes
    for (int m = 0; m < 4; m++) begin
      for (int x = 0; x < 2; x++) begin
        tx_mode_i = 2'(m); tx_xfer_i = 1'(x);
        rx_mode_i = 2'(m); rx_xfer_i = 1'(~x);
        settle(2);
        chk("R5 tx oe", tx_pad_oe, exp_oe(tx_sel_i, 2'(m), 1'(x)));
        chk("R5 rx oe", rx_pad_oe, exp_oe(rx_sel_i, 2'(m), 1'(~x)));
      end
    end

    // R6 illegal pad-source plus continuous
    tx_sel_i = 2'd2; tx_mode_i = 2'd1; rx_sel_i = 2'd2; rx_mode_i = 2'd1;
    settle(2);
    chk("R6 tx cfg err", tx_cfg_err_o, 1);
    chk("R6 rx cfg err", rx_cfg_err_o, 1);
    chk("R6 tx oe held low", tx_pad_oe, 0);
    chk("R6 rx oe held low", rx_pad_oe, 0);
    tx_mode_i = 2'd2; settle(2);
    chk("R6 tx err clears", tx_cfg_err_o, 0);

    // R8 external pad clocks, both directions
    pad_half = 5; rx_mode_i = 2'd0;
    settle(30);
    period(0, p); chk("R8 tx pad period", p, 10);
    period(1, p); chk("R8 rx pad period", p, 10);
    // R2 receive from transmit base, which is the pad
    rx_sel_i = 2'd1; settle(4); mis = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); mis += int'(rx_clk_o != tx_clk_o); end
    chk("R2 rx follows tx pad base", mis, 0);
    pad_half = 0;

    // R7 mutual loop
    tx_sel_i = 2'd1; rx_sel_i = 2'd1;
    settle(2);
    chk("R7 loop flag", loop_err_o, 1);
    count_pulses(60, a, b, h);
    chk("R7 no pulses", a + b + h, 0);
    tx_sel_i = 2'd0; settle(2);
    chk("R7 loop clears", loop_err_o, 0);

    // R3 divider stopped
    div_i = '0; rx_sel_i = 2'd0;
    settle(3);
    count_pulses(100, a, b, h);
    chk("R3 div=0 stops clock", a + b + h, 0);

    // Random divider and inversion
    for (int it = 0; it < 12; it++) begin
      int d = int'($urandom_range(15, 1));
      logic iv = 1'($urandom_range(1, 0));
      div_i = 12'(d); tx_sel_i = 2'd0; rx_sel_i = 2'd1; rx_inv_i = iv;
      settle(3);
      period(0, p); period(0, p);
      chk("R3 random period", p, exp_period(d));
      mis = 0;
      for (int i = 0; i < 2 * d + 4; i++) begin
        @(negedge clk); mis += int'(rx_clk_o != (tx_clk_o ^ iv));
      end
      chk("R4 random inversion", mis, 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule